// File: doc/BRIEF.md
# Radio Power Sequencing Controller

This controller brings an attached radio device up and down by driving four lines in a fixed order: a battery-rail enable, an I/O-rail enable, a chip enable and an active-low reset. A power-up request walks the outputs up one at a time. Each step is separated by a configurable gap counted in clock cycles. Reset is released only after the crystal oscillator has had time to settle, and that settle time is counted on an external one-millisecond tick.

A power-down request drops chip enable and reset together. After one gap the I/O rail falls, and after a second gap the battery rail falls. A power-down request that arrives while the oscillator is still settling abandons the power-up and starts the power-down at once. A busy flag covers every transitional state. A one-cycle done pulse marks the arrival in the fully-on state and the arrival in the fully-off state. The controller uses a synchronous reset that is active high.

Top module: `radio_pwr_seq`

## Requirements
- R1: While or right after synchronous reset, battEn, ioEn, chipEn, resetN, busy and done are all 0.
- R2: A power-up request in the off state sets battEn on the next edge. ioEn follows GAP_CYCLES cycles later, and chipEn follows GAP_CYCLES cycles after ioEn. ioEn is never 1 while battEn is 0, and chipEn is never 1 while ioEn is 0.
- R3: resetN rises only after at least SETTLE_MS+1 msTick pulses have been sampled since chipEn rose, so that at least SETTLE_MS full milliseconds elapse. Ticks seen before chipEn rises do not count.
- R4: On power-down, chipEn and resetN fall on the same edge while ioEn is still 1.
- R5: ioEn falls GAP_CYCLES cycles after chipEn falls, and battEn falls GAP_CYCLES cycles after that. battEn never falls while ioEn is 1.
- R6: A power-down request while waiting for oscillator settle aborts straight into the power-down sequence, and resetN is never released.
- R7: upReq has no effect outside the off state. downReq has no effect outside the settle-wait and fully-on states, and the outputs continue the sequence unchanged.
- R8: busy is 1 exactly when the controller is neither fully off (all four lines low) nor fully on (all four lines high).
- R9: done is 1 for exactly one cycle: the first cycle in the fully-on state and the first cycle back in the off state after a power-down. It is never 1 after reset alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upReq | input | 1 | Request to power the radio up |
| downReq | input | 1 | Request to power the radio down |
| msTick | input | 1 | One-cycle pulse every millisecond |
| battEn | output | 1 | Battery rail enable |
| ioEn | output | 1 | I/O rail enable |
| chipEn | output | 1 | Radio chip enable |
| resetN | output | 1 | Radio reset, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when fully on or fully off is reached |

## Verification
A wrong state shows at the pins within one edge, because every output is a register written by the same strobe that moves the state. A skipped step appears as two lines changing on one edge. A stuck gap counter appears as a line rising a cycle early or late. A miscounted settle window appears as resetN rising before the required tick count, which the bench catches on the exact edge. A wrongly ignored or wrongly honoured request shows on the edge after it, as a line that moves when it should hold.

// File: rtl/radio_pwr_seq_pkg.sv
package radio_pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_BATT_ON  = 3'd1,
    ST_IO_ON    = 3'd2,
    ST_EN_ON    = 3'd3,
    ST_SETTLE   = 3'd4,
    ST_RUNNING  = 3'd5,
    ST_PDOWN    = 3'd6
  } seqState_t;

  // Strobes from control to datapath; every one acts on the next edge.
  typedef struct packed {
    logic setBatt;
    logic setIo;
    logic setChip;
    logic releaseRst;
    logic dropChipRst;
    logic dropIo;
    logic dropBatt;
    logic clrGap;
    logic clrSettle;
    logic finish;
  } seqStrobe_t;

endpackage

// File: rtl/radio_pwr_seq_ctrl.sv
module radio_pwr_seq_ctrl
  import radio_pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upReq,
  input  logic       downReq,
  input  logic       gapDone,
  input  logic       settleDone,
  input  logic       ioOn,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_OFF: begin
        if (upReq) begin
          strobe.setBatt = 1'b1;
          strobe.clrGap  = 1'b1;
          nextState      = ST_BATT_ON;
        end
      end
      ST_BATT_ON: begin
        if (gapDone) begin
          strobe.setIo  = 1'b1;
          strobe.clrGap = 1'b1;
          nextState     = ST_IO_ON;
        end
      end
      ST_IO_ON: begin
        if (gapDone) begin
          strobe.setChip   = 1'b1;
          strobe.clrGap    = 1'b1;
          strobe.clrSettle = 1'b1;
          nextState        = ST_EN_ON;
        end
      end
      ST_EN_ON: begin
        if (gapDone) nextState = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (downReq) begin
          strobe.dropChipRst = 1'b1;
          strobe.clrGap      = 1'b1;
          nextState          = ST_PDOWN;
        end else if (settleDone) begin
          strobe.releaseRst = 1'b1;
          strobe.finish     = 1'b1;
          nextState         = ST_RUNNING;
        end
      end
      ST_RUNNING: begin
        if (downReq) begin
          strobe.dropChipRst = 1'b1;
          strobe.clrGap      = 1'b1;
          nextState          = ST_PDOWN;
        end
      end
      ST_PDOWN: begin
        if (gapDone) begin
          if (ioOn) begin
            strobe.dropIo = 1'b1;
            strobe.clrGap = 1'b1;
          end else begin
            strobe.dropBatt = 1'b1;
            strobe.finish   = 1'b1;
            nextState       = ST_OFF;
          end
        end
      end
      default: nextState = ST_OFF;
    endcase
  end

  assign busy = (state != ST_OFF) && (state != ST_RUNNING);

endmodule

// File: rtl/radio_pwr_seq_dp.sv
module radio_pwr_seq_dp
  import radio_pwr_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 4,
  parameter int SETTLE_MS  = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       msTick,
  input  seqStrobe_t strobe,
  output logic       gapDone,
  output logic       settleDone,
  output logic       battEn,
  output logic       ioEn,
  output logic       chipEn,
  output logic       resetN,
  output logic       done
);

  localparam int GAP_W        = $clog2(GAP_CYCLES + 1);
  localparam int SETTLE_TICKS = SETTLE_MS + 1;
  localparam int SETTLE_W     = $clog2(SETTLE_TICKS + 1);
  localparam logic [GAP_W-1:0]    GAP_LAST   = GAP_W'(GAP_CYCLES - 1);
  localparam logic [SETTLE_W-1:0] SETTLE_END = SETTLE_W'(SETTLE_TICKS);

  logic [GAP_W-1:0]    gapCnt;
  logic [SETTLE_W-1:0] settleCnt;

  assign gapDone    = (gapCnt == GAP_LAST);
  assign settleDone = (settleCnt == SETTLE_END);

  // Step gap: counts clock cycles, saturates at its last value.
  always_ff @(posedge clk) begin
    if (rst || strobe.clrGap) gapCnt <= '0;
    else if (!gapDone)        gapCnt <= gapCnt + 1'b1;
  end

  // Oscillator settle: counts ms ticks seen since chip enable was set.
  always_ff @(posedge clk) begin
    if (rst || strobe.clrSettle)   settleCnt <= '0;
    else if (msTick && !settleDone) settleCnt <= settleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      battEn <= 1'b0;
      ioEn   <= 1'b0;
      chipEn <= 1'b0;
      resetN <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (strobe.setBatt)          battEn <= 1'b1;
      else if (strobe.dropBatt)    battEn <= 1'b0;
      if (strobe.setIo)            ioEn   <= 1'b1;
      else if (strobe.dropIo)      ioEn   <= 1'b0;
      if (strobe.setChip)          chipEn <= 1'b1;
      else if (strobe.dropChipRst) chipEn <= 1'b0;
      if (strobe.releaseRst)       resetN <= 1'b1;
      else if (strobe.dropChipRst) resetN <= 1'b0;
      done <= strobe.finish;
    end
  end

endmodule

// File: rtl/radio_pwr_seq.sv
module radio_pwr_seq
  import radio_pwr_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 4,
  parameter int SETTLE_MS  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic upReq,
  input  logic downReq,
  input  logic msTick,
  output logic battEn,
  output logic ioEn,
  output logic chipEn,
  output logic resetN,
  output logic busy,
  output logic done
);

  seqStrobe_t strobe;
  logic       gapDone;
  logic       settleDone;

  radio_pwr_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .upReq      (upReq),
    .downReq    (downReq),
    .gapDone    (gapDone),
    .settleDone (settleDone),
    .ioOn       (ioEn),
    .strobe     (strobe),
    .busy       (busy)
  );

  radio_pwr_seq_dp #(
    .GAP_CYCLES (GAP_CYCLES),
    .SETTLE_MS  (SETTLE_MS)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .msTick     (msTick),
    .strobe     (strobe),
    .gapDone    (gapDone),
    .settleDone (settleDone),
    .battEn     (battEn),
    .ioEn       (ioEn),
    .chipEn     (chipEn),
    .resetN     (resetN),
    .done       (done)
  );

endmodule

// File: rtl/radio_pwr_seq_chk.sv
module radio_pwr_seq_chk #(
  parameter int SETTLE_MS = 5
) (
  input logic clk,
  input logic rst,
  input logic msTick,
  input logic battEn,
  input logic ioEn,
  input logic chipEn,
  input logic resetN,
  input logic busy,
  input logic done
);

  localparam int CNT_W = $clog2(SETTLE_MS + 3);
  localparam logic [CNT_W-1:0] NEED = CNT_W'(SETTLE_MS + 1);

  logic             rstQ;
  logic [CNT_W-1:0] ticksSinceEn;

  always_ff @(posedge clk) rstQ <= rst;

  // Independent count of ticks seen while chip enable is high.
  always_ff @(posedge clk) begin
    if (rst || !chipEn)                      ticksSinceEn <= '0;
    else if (msTick && ticksSinceEn < NEED)  ticksSinceEn <= ticksSinceEn + 1'b1;
  end

  assert_io_needs_batt_R2: assert property (@(posedge clk) disable iff (rst || rstQ)
    ioEn |-> battEn);

  assert_chip_needs_io_R2: assert property (@(posedge clk) disable iff (rst || rstQ)
    chipEn |-> ioEn);

  assert_settle_window_R3: assert property (@(posedge clk) disable iff (rst || rstQ)
    $rose(resetN) |-> (ticksSinceEn >= NEED));

  assert_reset_needs_chip_R3: assert property (@(posedge clk) disable iff (rst || rstQ)
    resetN |-> chipEn);

  assert_chip_falls_first_R4: assert property (@(posedge clk) disable iff (rst || rstQ)
    $fell(chipEn) |-> (!resetN && ioEn));

  assert_batt_falls_last_R5: assert property (@(posedge clk) disable iff (rst || rstQ)
    $fell(ioEn) |-> battEn);

  assert_idle_ends_R8: assert property (@(posedge clk) disable iff (rst || rstQ)
    !busy |-> ((!battEn && !ioEn && !chipEn && !resetN) ||
               (battEn && ioEn && chipEn && resetN)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst || rstQ)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst || rstQ)
    done |-> !busy);

endmodule

bind radio_pwr_seq radio_pwr_seq_chk #(.SETTLE_MS(SETTLE_MS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .msTick (msTick),
  .battEn (battEn),
  .ioEn   (ioEn),
  .chipEn (chipEn),
  .resetN (resetN),
  .busy   (busy),
  .done   (done)
);

// File: tb/radio_pwr_seq_tb.sv
module radio_pwr_seq_tb;

  localparam int CLK_NS = 10;
  localparam int NVEC   = 34;

  logic clk = 1'b0;
  logic rst, upReq, downReq, msTick;
  logic battEn, ioEn, chipEn, resetN, busy, done;

  int applied  = 0;
  int failures = 0;

  always #(CLK_NS/2) clk = ~clk;

  radio_pwr_seq #(.GAP_CYCLES(2), .SETTLE_MS(2)) u_dut (
    .clk(clk), .rst(rst), .upReq(upReq), .downReq(downReq), .msTick(msTick),
    .battEn(battEn), .ioEn(ioEn), .chipEn(chipEn), .resetN(resetN),
    .busy(busy), .done(done)
  );

  // {upReq, downReq, msTick, battEn, ioEn, chipEn, resetN, busy, done}
  // Outputs are those seen just after the edge that samples the inputs.
  localparam logic [8:0] VEC [NVEC] = '{
    9'b100_100010, // 0  R2 power-up request: battery rail on
    9'b000_100010, // 1  R2 gap
    9'b000_110010, // 2  R2 I/O rail on
    9'b000_110010, // 3
    9'b000_111010, // 4  R2 chip enable on
    9'b001_111010, // 5  R3 tick 1
    9'b000_111010, // 6  enter settle wait
    9'b001_111010, // 7  R3 tick 2
    9'b000_111010, // 8
    9'b001_111010, // 9  R3 tick 3 reaches count
    9'b000_111101, // 10 R3 reset released, R9 done, R8 idle
    9'b000_111100, // 11 R9 done gone
    9'b100_111100, // 12 R7 upReq ignored while on
    9'b010_110010, // 13 R4 chip and reset drop together
    9'b000_110010, // 14
    9'b000_100010, // 15 R5 I/O rail off
    9'b000_100010, // 16
    9'b000_000001, // 17 R5 battery rail off, R9 done
    9'b000_000000, // 18
    9'b010_000000, // 19 R7 downReq ignored while off
    9'b100_100010, // 20 second power-up
    9'b010_100010, // 21 R7 downReq ignored during rail steps
    9'b000_110010, // 22
    9'b000_110010, // 23
    9'b000_111010, // 24
    9'b000_111010, // 25
    9'b000_111010, // 26 settle wait
    9'b001_111010, // 27 tick 1
    9'b010_110010, // 28 R6 abort to power-down
    9'b000_110010, // 29
    9'b000_100010, // 30 R6 I/O rail off
    9'b000_100010, // 31
    9'b000_000001, // 32 R6 off, done
    9'b000_000000  // 33
  };

  function automatic string reqFor(input int idx);
    if (idx <= 4)        return "R2";
    else if (idx <= 10)  return "R3/R9";
    else if (idx == 12)  return "R7";
    else if (idx <= 14)  return "R4";
    else if (idx <= 18)  return "R5/R9";
    else if (idx <= 27)  return "R7";
    else                 return "R6";
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", applied, failures);
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] got;
    got = {battEn, ioEn, chipEn, resetN, busy, done};
    applied++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic drive(input logic u, input logic d, input logic t);
    @(negedge clk);
    upReq = u; downReq = d; msTick = t;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_NS * 200000);
    failures++;
    $display("FAIL watchdog expired: got hang expected finish");
    report();
    $finish;
  end

  initial begin
    rst = 1'b1; upReq = 1'b0; downReq = 1'b0; msTick = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 6'b000000);               // R1 reset state
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0);
    check("R9", 6'b000000);               // R9 no done pulse after reset alone

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][8], VEC[i][7], VEC[i][6]);
      check(reqFor(i), VEC[i][5:0]);
    end

    // R3: ticks in the off state and on the chip-enable edge do not count.
    repeat (4) drive(1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 1'b1);              // E0 battery rail
    repeat (3) drive(1'b0, 1'b0, 1'b1);   // E1..E3
    drive(1'b0, 1'b0, 1'b1);              // E4 chip enable, counter cleared
    check("R3", 6'b111010);
    repeat (3) drive(1'b0, 1'b0, 1'b1);   // E5..E7: three ticks counted
    check("R3", 6'b111010);               // reset still held
    drive(1'b0, 1'b0, 1'b0);              // E8 release
    check("R3", 6'b111101);

    // R1: synchronous reset in the middle of a sequence clears everything.
    drive(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1", 6'b000000);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0);
    check("R1", 6'b000000);

    report();
    $finish;
  end

endmodule